// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block governs the two low-power states of a small 8-bit microcontroller core. Software writes a two-bit power-control register. One bit requests idle, in which the CPU clock enable is dropped while peripherals, timers and the oscillator keep running. The other bit requests power-down, in which the CPU clock, the peripheral clocks and the oscillator enable are all dropped and state is simply held. While the core sleeps, the block also forces the address-latch and program-store strobes to fixed levels: high for idle, low for power-down.

Idle ends on any enabled interrupt that the interrupt controller reports as pending. Power-down ends only through an enabled, unmasked, level-sensitive external interrupt pin. The first low sample restarts the oscillator. The pin must then be sampled low for `HOLD_CYCLES` consecutive clocks and after that return high before service begins. When it rises too early, the block falls back into power-down and starts the count again. Each wake-up clears the mode bit and sends a one-cycle interrupt request to the core, which then resumes after the instruction that put it to sleep. An asynchronous reset, released synchronously inside the block, ends either mode at once.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A write (`ctl_wr`=1) is accepted only in run mode. If data bit 1 is set, power-down is entered (`ctl_rdata`=2'b10) even when bit 0 is also set. Otherwise, if bit 0 is set, idle is entered (`ctl_rdata`=2'b01). If neither bit is set, the block stays in run (`ctl_rdata`=2'b00). Writes made in any other mode have no effect.
- R2: In idle, `cpu_clk_en`=0, `periph_clk_en`=1 and `osc_en`=1.
- R3: In idle, a high `irq_pending` sampled at a clock edge returns the block to run at that edge and clears bit 0. A high `irq_pending` in run has no effect.
- R4: In power-down, `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0, and `irq_pending` has no effect.
- R5: In power-down, the external pin (`ext_irq_n`, active low) acts only when `ext_irq_en`=1, `ext_irq_level`=1 and `ext_irq_mask`=0. In any other combination, holding the pin low leaves `osc_en` at 0 and the mode at power-down.
- R6: Consecutive low samples of a qualifying pin are counted, starting with the first one taken in power-down. `osc_en` rises after that first sample. After `HOLD_CYCLES` low samples, the next high sample returns the block to run and clears bit 1.
- R7: If the pin is sampled high, or stops qualifying, before `HOLD_CYCLES` low samples have been counted, the block returns to power-down with `osc_en`=0 and no wake pulse, and the count restarts from zero.
- R8: `strobe_force` is 1 while asleep and 0 in run. With the strobes forced, `ale_lvl` and `psen_lvl` are both 1 in idle and both 0 from power-down entry until wake-up.
- R9: Every wake-up raises `wake_irq` for exactly one cycle, in the first cycle of run, with `cpu_clk_en`=1.
- R10: A low `rst_n` puts the block into run at once from any mode, with `ctl_rdata`=0, all clock enables 1, `strobe_force`=0 and `wake_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running model clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ctl_wr | input | 1 | Write strobe for the power-control register |
| ctl_wdata | input | 2 | Write data: bit 1 power-down, bit 0 idle |
| ctl_rdata | output | 2 | Current register value {power-down, idle} |
| irq_pending | input | 1 | An enabled interrupt is pending (idle wake source) |
| ext_irq_n | input | 1 | External interrupt pin, active low |
| ext_irq_en | input | 1 | External interrupt enabled |
| ext_irq_level | input | 1 | 1 = level-sensitive, 0 = edge-triggered |
| ext_irq_mask | input | 1 | 1 = external interrupt masked |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| strobe_force | output | 1 | Bus strobes are driven to sleep levels |
| ale_lvl | output | 1 | Address-latch strobe level while forced |
| psen_lvl | output | 1 | Program-store strobe level while forced |
| wake_irq | output | 1 | One-cycle interrupt request issued at wake-up |

## Verification
Two pairs of functions can meet in the same cycle. The first pair is an idle-entry write and a pending interrupt. The bench raises `irq_pending` in the same cycle as the write and expects the write to take effect first, so that idle is entered and then left one cycle later with a wake pulse. The second pair is the end of the hold count and the rise of the pin. A sweep raises the pin after every low-sample count from 1 to `HOLD_CYCLES`+2, using a small hold length. It expects a wake only when the pin was sampled low at least `HOLD_CYCLES` times. After each early rise it also checks that a second run of `HOLD_CYCLES`-1 low samples does not wake the core, which shows that the count was cleared.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    PM_RUN   = 3'd0,
    PM_IDLE  = 3'd1,
    PM_PDWN  = 3'd2,
    PM_HOLD  = 3'd3,
    PM_ARMED = 3'd4
  } pm_state_e;

  localparam int unsigned IDL_BIT = 0;
  localparam int unsigned PD_BIT  = 1;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmc_hold_cnt.sv
module pmc_hold_cnt #(
  parameter int unsigned HOLD_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST_V = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == LAST_V);
endmodule

// File: rtl/pmc_out_dec.sv
module pmc_out_dec
  import pmc_pkg::*;
(
  input  pm_state_e state,
  output logic      cpu_clk_en,
  output logic      periph_clk_en,
  output logic      osc_en,
  output logic      strobe_force,
  output logic      ale_lvl,
  output logic      psen_lvl
);
  always_comb begin
    cpu_clk_en    = 1'b1;
    periph_clk_en = 1'b1;
    osc_en        = 1'b1;
    strobe_force  = 1'b0;
    ale_lvl       = 1'b1;
    psen_lvl      = 1'b1;
    case (state)
      PM_IDLE: begin
        cpu_clk_en   = 1'b0;
        strobe_force = 1'b1;
      end
      PM_PDWN: begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = 1'b0;
        osc_en        = 1'b0;
        strobe_force  = 1'b1;
        ale_lvl       = 1'b0;
        psen_lvl      = 1'b0;
      end
      PM_HOLD, PM_ARMED: begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = 1'b0;
        strobe_force  = 1'b1;
        ale_lvl       = 1'b0;
        psen_lvl      = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_wdata,
  output logic [1:0] ctl_rdata,
  input  logic       irq_pending,
  input  logic       ext_irq_n,
  input  logic       ext_irq_en,
  input  logic       ext_irq_level,
  input  logic       ext_irq_mask,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       osc_en,
  output logic       strobe_force,
  output logic       ale_lvl,
  output logic       psen_lvl,
  output logic       wake_irq
);
  logic      rst_int_n;
  pm_state_e state_q, state_d;
  logic      idl_q, idl_d, pd_q, pd_d, wake_q, wake_d;
  logic      cnt_clr, cnt_inc, cnt_last, wake_lvl;

  pmc_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pmc_hold_cnt #(.HOLD_CYCLES(HOLD_CYCLES)) hold_cnt_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .last  (cnt_last)
  );

  // Only an enabled, unmasked, level-sensitive low pin can restart the core.
  assign wake_lvl = ext_irq_en & ext_irq_level & ~ext_irq_mask & ~ext_irq_n;

  always_comb begin
    state_d = state_q;
    idl_d   = idl_q;
    pd_d    = pd_q;
    wake_d  = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    case (state_q)
      PM_RUN: begin
        if (ctl_wr) begin
          if (ctl_wdata[PD_BIT]) begin
            pd_d    = 1'b1;
            idl_d   = 1'b0;
            cnt_clr = 1'b1;
            state_d = PM_PDWN;
          end else if (ctl_wdata[IDL_BIT]) begin
            idl_d   = 1'b1;
            state_d = PM_IDLE;
          end
        end
      end
      PM_IDLE: begin
        if (irq_pending) begin
          idl_d   = 1'b0;
          wake_d  = 1'b1;
          state_d = PM_RUN;
        end
      end
      PM_PDWN, PM_HOLD: begin
        if (wake_lvl) begin
          if (cnt_last) begin
            cnt_clr = 1'b1;
            state_d = PM_ARMED;
          end else begin
            cnt_inc = 1'b1;
            state_d = PM_HOLD;
          end
        end else begin
          cnt_clr = 1'b1;
          state_d = PM_PDWN;
        end
      end
      PM_ARMED: begin
        if (ext_irq_n) begin
          pd_d    = 1'b0;
          wake_d  = 1'b1;
          state_d = PM_RUN;
        end
      end
      default: begin
        idl_d   = 1'b0;
        pd_d    = 1'b0;
        state_d = PM_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= PM_RUN;
      idl_q   <= 1'b0;
      pd_q    <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idl_q   <= idl_d;
      pd_q    <= pd_d;
      wake_q  <= wake_d;
    end
  end

  pmc_out_dec out_dec_i (
    .state         (state_q),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .strobe_force  (strobe_force),
    .ale_lvl       (ale_lvl),
    .psen_lvl      (psen_lvl)
  );

  assign ctl_rdata = {pd_q, idl_q};
  assign wake_irq  = wake_q;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctl_rdata,
  input logic       ext_irq_n,
  input logic       ext_irq_level,
  input logic       cpu_clk_en,
  input logic       periph_clk_en,
  input logic       osc_en,
  input logic       strobe_force,
  input logic       ale_lvl,
  input logic       psen_lvl,
  input logic       wake_irq
);
  AST_BITS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_rdata[0] && ctl_rdata[1])); // R1

  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[0] |-> (!cpu_clk_en && periph_clk_en && osc_en)); // R2

  AST_PD_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[1] |-> (!cpu_clk_en && !periph_clk_en)); // R4

  AST_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[1] && !osc_en && !ext_irq_level) |=> !osc_en); // R5

  AST_PD_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && $past(ctl_rdata[1])) |-> $past(ext_irq_n)); // R6

  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[0] |-> (strobe_force && ale_lvl && psen_lvl)); // R8

  AST_PD_STROBES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[1] |-> (strobe_force && !ale_lvl && !psen_lvl)); // R8

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq); // R9

  AST_WAKE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (cpu_clk_en && !strobe_force && ctl_rdata == 2'b00)); // R9
endmodule

bind pwr_mode_ctrl pmc_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_rdata     (ctl_rdata),
  .ext_irq_n     (ext_irq_n),
  .ext_irq_level (ext_irq_level),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .osc_en        (osc_en),
  .strobe_force  (strobe_force),
  .ale_lvl       (ale_lvl),
  .psen_lvl      (psen_lvl),
  .wake_irq      (wake_irq)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  localparam int unsigned HOLD = 8;

  logic       clk = 1'b0;
  logic       rst_n, ctl_wr, irq_pending;
  logic [1:0] ctl_wdata, ctl_rdata;
  logic       ext_irq_n, ext_irq_en, ext_irq_level, ext_irq_mask;
  logic       cpu_clk_en, periph_clk_en, osc_en, strobe_force;
  logic       ale_lvl, psen_lvl, wake_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .irq_pending(irq_pending), .ext_irq_n(ext_irq_n),
    .ext_irq_en(ext_irq_en), .ext_irq_level(ext_irq_level),
    .ext_irq_mask(ext_irq_mask), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .strobe_force(strobe_force), .ale_lvl(ale_lvl), .psen_lvl(psen_lvl),
    .wake_irq(wake_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    tick();
    ctl_wr = 1'b0; ctl_wdata = 2'b00;
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    #1;
    chk("R10 reset bits", {30'd0, ctl_rdata}, 32'd0);
    chk("R10 reset enables", {29'd0, cpu_clk_en, periph_clk_en, osc_en}, 32'd7);
    chk("R10 reset force/wake", {30'd0, strobe_force, wake_irq}, 32'd0);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  // Pin low for nlow samples, then high; report whether a wake pulse followed.
  task automatic pin_cycle(input int nlow, output bit woke);
    ext_irq_n = 1'b0;
    repeat (nlow) tick();
    ext_irq_n = 1'b1;
    tick();
    woke = wake_irq;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    bit woke;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = 2'b00; irq_pending = 1'b0;
    ext_irq_n = 1'b1; ext_irq_en = 1'b1; ext_irq_level = 1'b1; ext_irq_mask = 1'b0;
    tick();
    hw_reset();

    // R3: pending interrupt in run has no effect
    irq_pending = 1'b1; tick();
    chk("R3 irq in run", {30'd0, ctl_rdata, wake_irq}, 32'd0);
    irq_pending = 1'b0;

    // R1 exhaustive over write data, with idle and power-down outputs
    for (int d = 0; d < 4; d++) begin
      logic [1:0] exp_bits;
      exp_bits = d[1] ? 2'b10 : (d[0] ? 2'b01 : 2'b00);
      do_write(2'(d));
      chk("R1 write decode", {30'd0, ctl_rdata}, {30'd0, exp_bits});
      if (exp_bits == 2'b01) begin
        chk("R2 idle enables", {29'd0, cpu_clk_en, periph_clk_en, osc_en}, 32'd3);
        chk("R8 idle strobes", {29'd0, strobe_force, ale_lvl, psen_lvl}, 32'd7);
        do_write(2'b10);
        chk("R1 write ignored in idle", {30'd0, ctl_rdata}, 32'd1);
        irq_pending = 1'b1; tick(); irq_pending = 1'b0;
        chk("R3 idle exit", {30'd0, ctl_rdata, wake_irq}, 32'd1);
        chk("R9 cpu back on", {31'd0, cpu_clk_en}, 32'd1);
        tick();
        chk("R9 pulse one cycle", {31'd0, wake_irq}, 32'd0);
      end else if (exp_bits == 2'b10) begin
        chk("R4 pd enables", {29'd0, cpu_clk_en, periph_clk_en, osc_en}, 32'd0);
        chk("R8 pd strobes", {29'd0, strobe_force, ale_lvl, psen_lvl}, 32'd4);
        irq_pending = 1'b1; repeat (4) tick(); irq_pending = 1'b0;
        chk("R4 irq ignored in pd", {29'd0, ctl_rdata, wake_irq}, 32'd4);
        hw_reset();
      end else begin
        chk("R8 run no force", {31'd0, strobe_force}, 32'd0);
      end
    end

    // Same cycle: idle write with interrupt already pending
    irq_pending = 1'b1;
    do_write(2'b01);
    chk("R1 write wins over pending irq", {29'd0, ctl_rdata, wake_irq}, 32'd2);
    tick(); irq_pending = 1'b0;
    chk("R3 exit one cycle later", {29'd0, ctl_rdata, wake_irq}, 32'd1);

    // R5 sweep over enable, level, mask
    for (int c = 0; c < 8; c++) begin
      bit qual;
      ext_irq_en = c[0]; ext_irq_level = c[1]; ext_irq_mask = c[2];
      qual = (c == 3);
      do_write(2'b10);
      ext_irq_n = 1'b0;
      repeat (HOLD + 3) tick();
      chk("R5 osc restart", {31'd0, osc_en}, {31'd0, qual});
      ext_irq_n = 1'b1; tick();
      chk("R5 wake only when qualified", {31'd0, wake_irq}, {31'd0, qual});
      chk("R5 mode after pin", {30'd0, ctl_rdata}, qual ? 32'd0 : 32'd2);
      if (!qual) hw_reset();
      else tick();
    end
    ext_irq_en = 1'b1; ext_irq_level = 1'b1; ext_irq_mask = 1'b0;

    // R6 / R7 hold-length sweep
    for (int k = 1; k <= HOLD + 2; k++) begin
      bit exp_w;
      exp_w = (k >= HOLD);
      do_write(2'b10);
      ext_irq_n = 1'b0; tick();
      chk("R6 osc on after first low", {31'd0, osc_en}, 32'd1);
      chk("R8 strobes low in hold", {29'd0, strobe_force, ale_lvl, psen_lvl}, 32'd4);
      repeat (k - 1) tick();
      ext_irq_n = 1'b1; tick();
      woke = wake_irq;
      chk("R6 wake vs hold count", {31'd0, woke}, {31'd0, exp_w});
      if (!exp_w) begin
        chk("R7 back to pd", {29'd0, ctl_rdata, osc_en}, 32'd4);
        pin_cycle(HOLD - 1, woke);
        chk("R7 count restarted", {31'd0, woke}, 32'd0);
        pin_cycle(HOLD, woke);
        chk("R6 full hold wakes", {31'd0, woke}, 32'd1);
      end
      chk("R6 pd bit cleared", {30'd0, ctl_rdata}, 32'd0);
      tick();
      chk("R9 pulse ended", {31'd0, wake_irq}, 32'd0);
    end

    // R7: losing qualification mid-hold also falls back
    do_write(2'b10);
    ext_irq_n = 1'b0; repeat (3) tick();
    ext_irq_mask = 1'b1; tick();
    chk("R7 mask mid-hold", {29'd0, ctl_rdata, osc_en}, 32'd4);
    ext_irq_mask = 1'b0; ext_irq_n = 1'b1; tick();

    // R10: reset during hold and during idle
    ext_irq_n = 1'b0; repeat (3) tick();
    hw_reset();
    ext_irq_n = 1'b1; tick();
    do_write(2'b01);
    hw_reset();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule